// File: doc/BRIEF.md
# Slotted Record Ring Buffer

This block is a circular store of decoded key-value records that sits between a record decoder (the producer) and a merge stage (the consumer). Storage is divided into a fixed number of slots. Each slot has a payload region, addressed in words, for the fully expanded key and value bytes. It also has a separate metadata word that carries the key length and the value length. The producer fills the slot under the write pointer word by word, writes its metadata, and then commits the slot. The consumer reads the metadata of the slot under the read pointer to learn how many payload words to fetch. It fetches those words with a one-cycle read latency and then releases the slot.

Occupancy is reported as a three-level status: empty, partly filled, full. A stall output is asserted while the buffer is full, so upstream logic can hold the decoder. It drops on its own once the consumer releases a slot. Illegal pointer moves are dropped and latch an error flag. The slot count and the slot size are parameters, so simulation can use small values.

Top module: `kv_slot_ring`

## Requirements
- R1: After reset the status is EMPTY (2'b00), the stall output is 0 and the error flag is 0.
- R2: The status is 2'b00 (EMPTY) when no slot is committed, 2'b01 (HALF_FULL) when 1 to SLOTS-1 slots are committed, and 2'b10 (FULL) when all SLOTS slots are committed. The code 2'b11 never appears.
- R3: Each accepted commit adds one slot to the occupancy and each accepted release removes one. `dec_stall` is 1 exactly while the status is FULL.
- R4: A commit while FULL is ignored: the status stays FULL. It also sets the error flag, which then stays 1 until reset.
- R5: A release while EMPTY is ignored: the status stays EMPTY and a following commit yields HALF_FULL. It also sets the sticky error flag.
- R6: A commit and a release in the same cycle while HALF_FULL leave the occupancy and the status unchanged.
- R7: Records come out in the order they were committed. Each record keeps its payload words and its metadata.
- R8: When `rd_req` is 1, `rd_data` holds the payload word at `rd_addr` of the slot under the read pointer one cycle later, and `rd_valid` is 1 in that cycle. `rd_valid` is 0 in the cycle after a cycle without `rd_req`.
- R9: Payload and metadata writes while FULL are ignored, so the oldest unread record is not corrupted.
- R10: The metadata word holds the key length in bits [31:16] and the value length in bits [15:0]. These are shown as `rd_key_len` and `rd_val_len` for the slot under the read pointer, with no latency.
- R11: Both pointers wrap from slot SLOTS-1 to slot 0, so records stay intact after any number of passes around the ring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write one payload word into the slot under the write pointer |
| wr_addr | input | $clog2(PAY_WORDS) | Payload word index within the slot |
| wr_data | input | DATA_W | Payload word |
| wr_meta_en | input | 1 | Write the metadata word of the slot under the write pointer |
| wr_key_len | input | LEN_W | Key length for the metadata |
| wr_val_len | input | LEN_W | Value length for the metadata |
| wr_commit | input | 1 | Hand the current slot to the consumer and advance the write pointer |
| rd_req | input | 1 | Request a payload word from the slot under the read pointer |
| rd_addr | input | $clog2(PAY_WORDS) | Payload word index to read |
| rd_data | output | DATA_W | Payload word, one cycle after the request |
| rd_valid | output | 1 | `rd_data` holds requested data |
| rd_key_len | output | LEN_W | Key length of the slot under the read pointer |
| rd_val_len | output | LEN_W | Value length of the slot under the read pointer |
| rd_release | input | 1 | Free the slot under the read pointer and advance the read pointer |
| status | output | 2 | Fill status: 00 empty, 01 half full, 10 full |
| dec_stall | output | 1 | Hold request for the decoder, set while full |
| err | output | 1 | Sticky flag for a commit while full or a release while empty |

## Verification
The assertions check the following on every cycle: status legality, stall matching the full status, commits refused at full, releases refused at empty, the error flag staying set, the unchanged status under a paired commit and release, and the one-cycle read valid timing. Only the bench scenarios can show that records come back in commit order with their payload and lengths intact across a pointer wrap. They also show that payload writes made while full leave the oldest record untouched, and that a release refused at empty does not corrupt the count that later commits build on.

// File: rtl/kv_slot_ring.sv
module kv_slot_ring #(
  parameter int SLOTS     = 32,
  parameter int PAY_WORDS = 12,
  parameter int DATA_W    = 32,
  parameter int LEN_W     = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [$clog2(PAY_WORDS)-1:0] wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic                         wr_meta_en,
  input  logic [LEN_W-1:0]             wr_key_len,
  input  logic [LEN_W-1:0]             wr_val_len,
  input  logic                         wr_commit,
  input  logic                         rd_req,
  input  logic [$clog2(PAY_WORDS)-1:0] rd_addr,
  output logic [DATA_W-1:0]            rd_data,
  output logic                         rd_valid,
  output logic [LEN_W-1:0]             rd_key_len,
  output logic [LEN_W-1:0]             rd_val_len,
  input  logic                         rd_release,
  output logic [1:0]                   status,
  output logic                         dec_stall,
  output logic                         err
);
  localparam int PTR_W = $clog2(SLOTS);
  localparam int CNT_W = PTR_W + 1;
  localparam int AW    = $clog2(SLOTS * PAY_WORDS);

  logic [DATA_W-1:0]  pay  [SLOTS*PAY_WORDS];
  logic [2*LEN_W-1:0] meta [SLOTS];

  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;

  wire full    = (count == CNT_W'(SLOTS));
  wire empty   = (count == '0);
  wire push_ok = wr_commit && !full;
  wire pop_ok  = rd_release && !empty;

  wire [AW-1:0] wr_idx = AW'(wr_ptr) * AW'(PAY_WORDS) + AW'(wr_addr);
  wire [AW-1:0] rd_idx = AW'(rd_ptr) * AW'(PAY_WORDS) + AW'(rd_addr);

  function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(SLOTS - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en && !full)      pay[wr_idx]  <= wr_data;
    if (wr_meta_en && !full) meta[wr_ptr] <= {wr_key_len, wr_val_len};
    if (rd_req)              rd_data      <= pay[rd_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      rd_valid <= 1'b0;
      err      <= 1'b0;
    end else begin
      rd_valid <= rd_req;
      if (push_ok) wr_ptr <= next_ptr(wr_ptr);
      if (pop_ok)  rd_ptr <= next_ptr(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if ((wr_commit && full) || (rd_release && empty)) err <= 1'b1;
    end
  end

  assign rd_key_len = meta[rd_ptr][2*LEN_W-1:LEN_W];
  assign rd_val_len = meta[rd_ptr][LEN_W-1:0];
  assign status     = empty ? 2'b00 : (full ? 2'b10 : 2'b01);
  assign dec_stall  = full;
endmodule

// File: rtl/kv_slot_ring_chk.sv
module kv_slot_ring_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_commit,
  input logic       rd_release,
  input logic       rd_req,
  input logic       rd_valid,
  input logic [1:0] status,
  input logic       dec_stall,
  input logic       err
);
  assert_status_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    status != 2'b11);
  assert_stall_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dec_stall == (status == 2'b10));
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_commit && !rd_release && status == 2'b10) |=> (status == 2'b10 && err));
  assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_release && !wr_commit && status == 2'b00) |=> (status == 2'b00 && err));
  assert_pair_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_commit && rd_release && status == 2'b01) |=> $stable(status));
  assert_rd_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);
  assert_rd_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);
endmodule

bind kv_slot_ring kv_slot_ring_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_commit(wr_commit), .rd_release(rd_release),
  .rd_req(rd_req), .rd_valid(rd_valid), .status(status),
  .dec_stall(dec_stall), .err(err)
);

// File: tb/kv_slot_ring_bench.sv
module kv_slot_ring_bench;
  localparam int SLOTS = 4;
  localparam int PW    = 4;
  localparam int AWB   = $clog2(PW);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 0, wr_meta_en = 0, wr_commit = 0, rd_req = 0, rd_release = 0;
  logic [AWB-1:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [15:0] wr_key_len = '0, wr_val_len = '0;
  logic [31:0] rd_data;
  logic rd_valid, dec_stall, err;
  logic [15:0] rd_key_len, rd_val_len;
  logic [1:0] status;
  int checks = 0, fails = 0;

  always #5ns clk = ~clk;

  kv_slot_ring #(.SLOTS(SLOTS), .PAY_WORDS(PW), .DATA_W(32), .LEN_W(16)) u_kv_slot_ring (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .wr_meta_en, .wr_key_len, .wr_val_len,
    .wr_commit, .rd_req, .rd_addr, .rd_data, .rd_valid, .rd_key_len, .rd_val_len,
    .rd_release, .status, .dec_stall, .err);

  // vector: [4] commit, [3] release, [2:1] expected status, [0] expected err
  localparam logic [4:0] VEC [12] = '{
    5'b10_01_0, 5'b10_01_0, 5'b11_01_0, 5'b10_01_0, 5'b10_10_0, 5'b01_01_0,
    5'b10_10_0, 5'b00_10_0, 5'b01_01_0, 5'b01_01_0, 5'b01_01_0, 5'b01_00_0};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step();
    rst_n = 1'b1;
    step();
  endtask

  function automatic logic [31:0] word_of(input int rec, input int w);
    return 32'hA000_0000 + 32'(rec * 16 + w);
  endfunction

  initial begin
    #2ms;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    chk("R1 status", 64'(status), 64'(2'b00));
    chk("R1 stall", 64'(dec_stall), 64'd0);
    chk("R1 err", 64'(err), 64'd0);

    foreach (VEC[i]) begin
      wr_commit  = VEC[i][4];
      rd_release = VEC[i][3];
      step();
      wr_commit = 0; rd_release = 0;
      chk($sformatf("R2 R3 R6 vector %0d status", i), 64'(status), 64'(VEC[i][2:1]));
      chk($sformatf("R3 vector %0d stall", i), 64'(dec_stall), 64'(VEC[i][2:1] == 2'b10));
      chk($sformatf("R4 R5 vector %0d err", i), 64'(err), 64'(VEC[i][0]));
    end

    // pointers now sit at slot 2: the four records below wrap (R11)
    for (int r = 0; r < SLOTS; r++) begin
      for (int w = 0; w < PW; w++) begin
        wr_en = 1; wr_addr = AWB'(w); wr_data = word_of(r, w);
        step();
      end
      wr_en = 0;
      wr_meta_en = 1; wr_key_len = 16'(r + 1); wr_val_len = 16'(10 + r);
      step();
      wr_meta_en = 0;
      wr_commit = 1;
      step();
      wr_commit = 0;
    end
    chk("R2 full status", 64'(status), 64'(2'b10));
    chk("R3 stall when full", 64'(dec_stall), 64'd1);

    wr_en = 1; wr_addr = '0; wr_data = 32'hDEAD_BEEF;
    wr_meta_en = 1; wr_key_len = 16'hFFFF; wr_val_len = 16'hFFFF;
    step();
    wr_en = 0; wr_meta_en = 0;
    wr_commit = 1;
    step();
    wr_commit = 0;
    chk("R4 status stays full", 64'(status), 64'(2'b10));
    chk("R4 err set", 64'(err), 64'd1);

    for (int r = 0; r < SLOTS; r++) begin
      chk($sformatf("R10 R7 key len rec %0d", r), 64'(rd_key_len), 64'(r + 1));
      chk($sformatf("R10 R9 val len rec %0d", r), 64'(rd_val_len), 64'(10 + r));
      for (int w = PW - 1; w >= 0; w--) begin
        rd_req = 1; rd_addr = AWB'(w);
        step();
        chk($sformatf("R8 valid rec %0d", r), 64'(rd_valid), 64'd1);
        chk($sformatf("R7 R9 R11 data rec %0d word %0d", r, w), 64'(rd_data), 64'(word_of(r, w)));
      end
      rd_req = 0;
      step();
      chk("R8 valid drops", 64'(rd_valid), 64'd0);
      rd_release = 1;
      step();
      rd_release = 0;
      chk($sformatf("R3 status after release %0d", r), 64'(status),
          64'((r == SLOTS - 1) ? 2'b00 : 2'b01));
    end
    chk("R4 err sticky", 64'(err), 64'd1);

    do_reset();
    chk("R1 err cleared", 64'(err), 64'd0);
    rd_release = 1;
    step();
    rd_release = 0;
    chk("R5 status stays empty", 64'(status), 64'(2'b00));
    chk("R5 err set", 64'(err), 64'd1);
    wr_commit = 1;
    step();
    wr_commit = 0;
    chk("R5 count not corrupted", 64'(status), 64'(2'b01));
    rd_release = 1;
    step();
    rd_release = 0;
    chk("R5 one release empties", 64'(status), 64'(2'b00));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule